// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This block keeps wall-clock time and calendar date for a chip that runs a slow real-time clock. A two-stage divider (a short first stage feeding a long second stage) turns the input clock into a one-per-second tick. Each tick advances a fully BCD-coded calendar of seconds, minutes, hours, weekday, day of month, month and a two-digit year covering 2000 to 2099. Every field rolls over at its own limit. Month lengths follow the Gregorian rules, and February has 29 days in every year whose two-digit value divides by four.

Software sees the calendar as two packed 32-bit words, one for time and one for date, and sees the divider as a third word. It can always read them. It can only change them while the external init signal is high. While init is high, both divider stages are held cleared and no calendar field moves. Once init drops, the first advance comes one full divider period later, counted from the loaded values.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time word reads 0x00000000 (00:00:00), the date word reads 0x00002101 (weekday 1, month 01, day 01, year 00), the divider word reads 0x007F00FF, and tick_o is low.
- R2: The divider word holds the first-stage value A in bits 22:16 and the second-stage value S in bits 14:0. tick_o pulses for one cycle every (A+1)*(S+1) input cycles.
- R3: A write strobe for the time, date or divider word takes wdata_i only in a cycle where init_i is high. Outside init the strobe has no effect on any readback word.
- R4: While init_i is high, no calendar field changes except by a load, and the divider is held cleared. The first advance after init_i falls lands on the (A+1)*(S+1)-th rising edge.
- R5: The time word carries BCD seconds in bits 6:0, BCD minutes in bits 14:8 and BCD hours in bits 21:16. Seconds and minutes count 00 to 59, and a wrap from 59 to 00 carries into the next field.
- R6: Hours count in 24-hour form from 00 to 23. The tick after 23:59:59 gives 00:00:00 and advances the date by one day.
- R7: The weekday in bits 15:13 of the date word counts 1 to 7. It wraps from 7 to 1 at each midnight.
- R8: The date word carries BCD day in bits 5:0, BCD month in bits 12:8 and BCD year in bits 23:16. The day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other non-February months.
- R9: In February the day wraps to 01 after day 29 when the year value divides by 4 (00 included), and after day 28 otherwise.
- R10: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Init mode: freezes counting and enables loads |
| wr_time_i | input | 1 | Load strobe for the time word |
| wr_date_i | input | 1 | Load strobe for the date word |
| wr_div_i | input | 1 | Load strobe for the divider word |
| wdata_i | input | 32 | Data for the load strobes |
| time_o | output | 32 | Packed BCD time word |
| date_o | output | 32 | Packed BCD date word |
| div_o | output | 32 | Divider configuration readback |
| tick_o | output | 1 | One-cycle pulse on each calendar advance |

## Verification
The hard case is a single tick whose carry ripples through every field in the same cycle. Seconds, minutes, hours, weekday, day, month and year must all wrap on one edge. The bench provokes this by loading 23:59:59 on 31 December of year 99 with weekday 7 neighbours nearby. It then releases init for exactly one divider period and compares both words against a computed 00:00:00 on 1 January of year 00. Partial ripples (end of a short month, February in leap and non-leap years, end of year, weekday 7) are judged the same way. A separate step pairs a release from init with a write strobe to show that loads and counting never meet in one cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   typedef struct packed {
      logic [5:0] hour;
      logic [6:0] min;
      logic [6:0] sec;
   } tod_t;

   typedef struct packed {
      logic [7:0] year;
      logic [2:0] wday;
      logic [4:0] mon;
      logic [5:0] day;
   } cal_t;

   // Two-digit BCD increment (no range check, caller decides wrap)
   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // (10*t + u) mod 4 equals (2*t + u) mod 4
   function automatic logic is_leap(input logic [7:0] y);
      logic [1:0] r;
      r = {y[4], 1'b0} + y[1:0];
      return (r == 2'd0);
   endfunction

   function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] y);
      case (mon)
         5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int A_W = 7,
   parameter int S_W = 15
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic [A_W-1:0] a_lim,
   input  logic [S_W-1:0] s_lim,
   output logic           tick
);
   logic [A_W-1:0] a_cnt;
   logic [S_W-1:0] s_cnt;
   logic           a_wrap;

   assign a_wrap = (a_cnt == a_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt <= '0;
         s_cnt <= '0;
      end else if (hold) begin
         a_cnt <= '0;
         s_cnt <= '0;
      end else if (a_wrap) begin
         a_cnt <= '0;
         s_cnt <= (s_cnt == s_lim) ? '0 : s_cnt + 1'b1;
      end else begin
         a_cnt <= a_cnt + 1'b1;
      end
   end

   assign tick = !hold && a_wrap && (s_cnt == s_lim);

endmodule

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
   import rtc_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ld,
   input  tod_t ld_val,
   output tod_t q,
   output logic day_carry
);
   logic sec_end, min_end, hr_end;
   logic [7:0] s_nx, m_nx, h_nx;

   assign sec_end = (q.sec  == 7'h59);
   assign min_end = (q.min  == 7'h59);
   assign hr_end  = (q.hour == 6'h23);
   assign s_nx    = bcd_step({1'b0, q.sec});
   assign m_nx    = bcd_step({1'b0, q.min});
   assign h_nx    = bcd_step({2'b0, q.hour});
   assign day_carry = tick && sec_end && min_end && hr_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld) begin
         q <= ld_val;
      end else if (tick) begin
         q.sec <= sec_end ? 7'h00 : s_nx[6:0];
         if (sec_end) begin
            q.min <= min_end ? 7'h00 : m_nx[6:0];
            if (min_end) q.hour <= hr_end ? 6'h00 : h_nx[5:0];
         end
      end
   end

endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
   import rtc_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic day_tick,
   input  logic ld,
   input  cal_t ld_val,
   output cal_t q
);
   logic       day_end, mon_end;
   logic [7:0] d_nx, m_nx, y_nx;

   assign day_end = (q.day == last_day(q.mon, q.year));
   assign mon_end = (q.mon == 5'h12);
   assign d_nx    = bcd_step({2'b0, q.day});
   assign m_nx    = bcd_step({3'b0, q.mon});
   assign y_nx    = (q.year == 8'h99) ? 8'h00 : bcd_step(q.year);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '{year: 8'h00, wday: 3'd1, mon: 5'h01, day: 6'h01};
      end else if (ld) begin
         q <= ld_val;
      end else if (day_tick) begin
         q.wday <= (q.wday == 3'd7) ? 3'd1 : q.wday + 3'd1;
         q.day  <= day_end ? 6'h01 : d_nx[5:0];
         if (day_end) begin
            q.mon <= mon_end ? 5'h01 : m_nx[4:0];
            if (mon_end) q.year <= y_nx;
         end
      end
   end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int A_W   = 7,
   parameter int S_W   = 15,
   parameter int A_RST = 127,
   parameter int S_RST = 255
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init_i,
   input  logic        wr_time_i,
   input  logic        wr_date_i,
   input  logic        wr_div_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] time_o,
   output logic [31:0] date_o,
   output logic [31:0] div_o,
   output logic        tick_o
);
   localparam int A_POS = 16;
   localparam int S_POS = 0;

   generate
      if (A_W < 1 || A_W > 7) begin : g_bad_a
         $error("A_W must be 1..7");
      end
      if (S_W < 1 || S_W > 15) begin : g_bad_s
         $error("S_W must be 1..15");
      end
      if (A_RST >= (1 << A_W) || S_RST >= (1 << S_W)) begin : g_bad_rst
         $error("divider reset value exceeds field width");
      end
   endgenerate

   logic [A_W-1:0] a_q;
   logic [S_W-1:0] s_q;
   logic           day_tick;
   tod_t           tod_q, tod_ld;
   cal_t           cal_q, cal_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= A_W'(A_RST);
         s_q <= S_W'(S_RST);
      end else if (init_i && wr_div_i) begin
         a_q <= wdata_i[A_POS +: A_W];
         s_q <= wdata_i[S_POS +: S_W];
      end
   end

   rtc_prescaler #(.A_W(A_W), .S_W(S_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .hold(init_i),
      .a_lim(a_q), .s_lim(s_q), .tick(tick_o)
   );

   assign tod_ld = '{hour: wdata_i[21:16], min: wdata_i[14:8], sec: wdata_i[6:0]};
   assign cal_ld = '{year: wdata_i[23:16], wday: wdata_i[15:13],
                     mon: wdata_i[12:8], day: wdata_i[5:0]};

   rtc_tod_counter u_tod (
      .clk(clk), .rst_n(rst_n), .tick(tick_o),
      .ld(init_i && wr_time_i), .ld_val(tod_ld),
      .q(tod_q), .day_carry(day_tick)
   );

   rtc_date_counter u_cal (
      .clk(clk), .rst_n(rst_n), .day_tick(day_tick),
      .ld(init_i && wr_date_i), .ld_val(cal_ld), .q(cal_q)
   );

   always_comb begin
      time_o = '0;
      time_o[21:16] = tod_q.hour;
      time_o[14:8]  = tod_q.min;
      time_o[6:0]   = tod_q.sec;
      date_o = '0;
      date_o[23:16] = cal_q.year;
      date_o[15:13] = cal_q.wday;
      date_o[12:8]  = cal_q.mon;
      date_o[5:0]   = cal_q.day;
      div_o = '0;
      div_o[A_POS +: A_W] = a_q;
      div_o[S_POS +: S_W] = s_q;
   end

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        init_i,
   input logic        wr_time_i,
   input logic        wr_date_i,
   input logic        wr_div_i,
   input logic [31:0] time_o,
   input logic [31:0] date_o,
   input logic [31:0] div_o,
   input logic        tick_o
);
   // R3: divider word never moves outside init
   a_r3_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !init_i |=> $stable(div_o));

   // R3: outside init, only a tick moves the calendar
   a_r3_cal_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !tick_o) |=> ($stable(time_o) && $stable(date_o)));

   // R4: frozen during init when nothing is loaded
   a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (init_i && !wr_time_i && !wr_date_i) |=> ($stable(time_o) && $stable(date_o)));

   // R5: a tick always changes the time word
   a_r5_tick_moves: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !$stable(time_o));

   // R5: seconds stay valid BCD 00..59
   a_r5_sec_bcd: assert property (@(posedge clk) disable iff (!rst_n)
      (time_o[3:0] <= 4'd9) && (time_o[6:4] <= 3'd5));

   // R6: hours never exceed 23
   a_r6_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
      time_o[21:16] <= 6'h23);

   // R7: weekday never reads 0
   a_r7_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
      date_o[15:13] != 3'd0);

   // R10: month stays within 01..12
   a_r10_month_range: assert property (@(posedge clk) disable iff (!rst_n)
      (date_o[12:8] >= 5'h01) && (date_o[12:8] <= 5'h12));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .init_i(init_i), .wr_time_i(wr_time_i),
   .wr_date_i(wr_date_i), .wr_div_i(wr_div_i), .time_o(time_o),
   .date_o(date_o), .div_o(div_o), .tick_o(tick_o)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_i = 1'b0, wr_time_i = 1'b0, wr_date_i = 1'b0, wr_div_i = 1'b0;
   logic [31:0] wdata_i = '0;
   logic [31:0] time_o, date_o, div_o;
   logic        tick_o;
   int          errors = 0, checks = 0;

   always #2.5 clk = ~clk;

   rtc_calendar_core u_dut (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .wr_time_i(wr_time_i),
      .wr_date_i(wr_date_i), .wr_div_i(wr_div_i), .wdata_i(wdata_i),
      .time_o(time_o), .date_o(date_o), .div_o(div_o), .tick_o(tick_o)
   );

   typedef struct packed {
      logic [23:0] tag;
      logic [31:0] t_in;
      logic [31:0] d_in;
      logic [7:0]  k;
      logic [31:0] t_exp;
      logic [31:0] d_exp;
   } vec_t;

   localparam int NV = 14;
   localparam int PER = 4;  // divider A=1, S=1
   localparam vec_t VECS [NV] = '{
      '{"R5 ", 32'h00123456, 32'h0024A315, 8'd1,  32'h00123457, 32'h0024A315},
      '{"R5 ", 32'h00123459, 32'h0024A315, 8'd1,  32'h00123500, 32'h0024A315},
      '{"R5 ", 32'h00125959, 32'h0024A315, 8'd1,  32'h00130000, 32'h0024A315},
      '{"R6 ", 32'h00235959, 32'h0024A315, 8'd1,  32'h00000000, 32'h0024C316},
      '{"R7 ", 32'h00235959, 32'h0023E630, 8'd1,  32'h00000000, 32'h00232701},
      '{"R9 ", 32'h00235959, 32'h00246228, 8'd1,  32'h00000000, 32'h00248229},
      '{"R9 ", 32'h00235959, 32'h00248229, 8'd1,  32'h00000000, 32'h0024A301},
      '{"R9 ", 32'h00235959, 32'h00234228, 8'd1,  32'h00000000, 32'h00236301},
      '{"R9 ", 32'h00235959, 32'h00002228, 8'd1,  32'h00000000, 32'h00004229},
      '{"R8 ", 32'h00235959, 32'h00256430, 8'd1,  32'h00000000, 32'h00258501},
      '{"R8 ", 32'h00235959, 32'h00202930, 8'd1,  32'h00000000, 32'h00205001},
      '{"R10", 32'h00235959, 32'h00245231, 8'd1,  32'h00000000, 32'h00256101},
      '{"R10", 32'h00235959, 32'h00999231, 8'd1,  32'h00000000, 32'h0000A101},
      '{"R4 ", 32'h00000000, 32'h00002101, 8'd15, 32'h00000015, 32'h00002101}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Load both words during init, release, run k periods, leave init raised again.
   task automatic run_vec(input logic [31:0] t, input logic [31:0] d, input int k);
      @(negedge clk); init_i = 1'b1; wr_time_i = 1'b1; wdata_i = t;
      @(negedge clk); wr_time_i = 1'b0; wr_date_i = 1'b1; wdata_i = d;
      @(negedge clk); wr_date_i = 1'b0; init_i = 1'b0;
      repeat (PER * k) @(negedge clk);
      init_i = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [31:0] t0, d0, v0;
      int ticks, first;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 time", time_o, 32'h00000000);
      chk("R1 date", date_o, 32'h00002101);
      chk("R1 div",  div_o,  32'h007F00FF);
      chk("R1 tick", {31'b0, tick_o}, 32'h0);
      rst_n = 1'b1; init_i = 1'b1;
      @(negedge clk); wr_div_i = 1'b1; wdata_i = 32'h00010001;
      @(negedge clk); wr_div_i = 1'b0;
      chk("R3 div load", div_o, 32'h00010001);

      // R3 load in init reads back before counting
      @(negedge clk); wr_time_i = 1'b1; wdata_i = 32'h00071122;
      @(negedge clk); wr_time_i = 1'b0;
      chk("R3 time load", time_o, 32'h00071122);

      for (int i = 0; i < NV; i++) begin
         run_vec(VECS[i].t_in, VECS[i].d_in, int'(VECS[i].k));
         chk({string'(VECS[i].tag), " time"}, time_o, VECS[i].t_exp);
         chk({string'(VECS[i].tag), " date"}, date_o, VECS[i].d_exp);
      end

      // R4 frozen for many cycles in init
      t0 = time_o; d0 = date_o;
      repeat (40) @(negedge clk);
      chk("R4 frozen time", time_o, t0);
      chk("R4 frozen date", date_o, d0);

      // R3 strobes outside init ignored (release and write two edges apart, before any tick)
      v0 = div_o;
      @(negedge clk); init_i = 1'b0;
      @(negedge clk); wr_time_i = 1'b1; wr_date_i = 1'b1; wr_div_i = 1'b1; wdata_i = 32'h00111111;
      @(negedge clk); wr_time_i = 1'b0; wr_date_i = 1'b0; wr_div_i = 1'b0;
      chk("R3 ignored time", time_o, t0);
      chk("R3 ignored date", date_o, d0);
      chk("R3 ignored div",  div_o,  v0);
      init_i = 1'b1;

      // R2 divider period with A=2, S=1: six cycles per tick
      @(negedge clk); wr_div_i = 1'b1; wr_time_i = 1'b1; wdata_i = 32'h00020001;
      @(negedge clk); wr_div_i = 1'b0; wr_time_i = 1'b0;
      chk("R2 div readback", div_o, 32'h00020001);
      @(negedge clk); wr_time_i = 1'b1; wdata_i = 32'h00000000;
      @(negedge clk); wr_time_i = 1'b0; init_i = 1'b0;
      ticks = 0; first = -1;
      for (int c = 1; c <= 60; c++) begin
         @(negedge clk);
         if (tick_o) begin
            ticks++;
            if (first < 0) first = c;
         end
      end
      init_i = 1'b1;
      chk("R2 tick count", 32'(ticks), 32'd10);
      chk("R4 first tick cycle", 32'(first), 32'd5);
      chk("R2 seconds advanced", time_o, 32'h00000010);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule